// File: doc/BRIEF.md
# Grouped Table-Based Angle Accumulator

This block forms the angle output of a vectoring-mode shift-and-add arctangent unit. It does not use one adder/subtractor per iteration. It splits the iteration direction bits into consecutive groups. Each group addresses a small constant table, and that table holds the signed sum of the normalised arctangent steps its bits select. One adder per group folds the table entry into the running angle.

The first group spans six iterations. Every later group spans five iterations, and the last group takes whatever remains. With the default width of 24 bits there are 25 iterations, so the group sizes are 6, 5, 5, 5 and 4. A direction bit for the pre-rotation selects a ±half-turn-of-half offset, which is added to the first stage. The running angle carries `G` guard bits below the output precision and is rounded once at the end. Angles are fractions of pi in two's complement, so an output code `c` stands for `c / 2^(W-1)` times pi.

The whole direction vector arrives in a single cycle, qualified by a valid bit. Each group stage is registered. Delay lines give every stage its own direction bits, aligned with the sample that stage is processing. A new vector can be accepted on every clock.

Top module: `grouped_angle_accum`

## Requirements
- R1: While reset is held and right after it is released, `angle_valid` is 0 and `angle` is all zeros.
- R2: For each cycle in which `dir_valid` is sampled high, `angle_valid` is high for exactly one cycle. That cycle comes NG+1 clock edges later, where NG is the number of groups (6 edges for the defaults). A new vector is accepted on every clock with no stall.
- R3: `dir_bits[0]` is the pre-rotation bit and `dir_bits[i+1]` is the direction of iteration i, for i = 0..W. A bit value of 1 means +1 and adds +atan(2^-i)/pi. A bit value of 0 means -1 and adds -atan(2^-i)/pi.
- R4: When `dir_bits[0]`=1 the starting angle is +0.5, otherwise it is -0.5. Changing only that bit changes `angle` by exactly 2^(W-1) modulo 2^W.
- R5: The groups cover iterations 0..5, then runs of 5, and the last group takes the remainder. Each group's signed arctangent sum is rounded to the nearest multiple of 2^-(W+G-1) before it is accumulated.
- R6: The output is formed from the (W+G)-bit sum by adding 2^(G-1), shifting right arithmetically by G, and keeping W bits.
- R7: Sums beyond ±1.0 wrap in two's complement and do not saturate.
- R8: `angle` keeps its previous value in every cycle where `angle_valid` is low.
- R9: Every output lies within one output LSB of the exact value of offset plus the sum of d_i·atan(2^-i)/pi, measured modulo 2.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_valid | input | 1 | Direction vector present this cycle |
| dir_bits | input | W+2 | Bit 0: pre-rotation direction; bit i+1: direction of iteration i |
| angle_valid | output | 1 | Angle present this cycle |
| angle | output | W | Angle as a signed fraction of pi |

## Verification
Each output is compared against a behavioural model that computes its own group sums with the runtime arctangent and rounds each sum to the internal step. A mismatch in table contents, group boundaries, bit order or rounding therefore shows up as a code difference, not just as a loss of accuracy. All-ones and all-zeros vectors push the sum past ±1.0, which separates wrapping from saturation. A pair of vectors that differ only in the pre-rotation bit isolates the offset. Long back-to-back random runs, and runs broken by idle gaps, separate true per-cycle throughput and correct delay-line alignment from a design that only works on isolated samples.

// File: rtl/gaa_pkg.sv
package gaa_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // atan(2^-i) / pi, from a power series (exact 0.25 for i = 0)
  function automatic real atan_frac(input int i);
    real x, x2, p, s;
    if (i == 0) return 0.25;
    x = 1.0;
    for (int k = 0; k < i; k++) x = x / 2.0;
    x2 = x * x;
    p = x;
    s = 0.0;
    for (int k = 0; k < 40; k++) begin
      if (k % 2 == 0) s = s + p / (2 * k + 1);
      else            s = s - p / (2 * k + 1);
      p = p * x2;
    end
    return s / PI_R;
  endfunction

  function automatic int group_count(input int nit, input int first, input int rest);
    if (nit <= first) return 1;
    return 1 + (nit - first + rest - 1) / rest;
  endfunction

  function automatic int group_start(input int k, input int first, input int rest);
    if (k == 0) return 0;
    return first + (k - 1) * rest;
  endfunction

  function automatic int group_size(input int k, input int nit, input int first, input int rest);
    int rem, cap;
    rem = nit - group_start(k, first, rest);
    cap = (k == 0) ? first : rest;
    return (rem < cap) ? rem : cap;
  endfunction

  // signed sum of the selected arctangent steps, in units of 2^-fbits
  function automatic longint group_entry(input int start, input int n,
                                         input int idx, input int fbits);
    real s, sc;
    s = 0.0;
    for (int j = 0; j < n; j++) begin
      if (((idx >> j) & 1) == 1) s = s + atan_frac(start + j);
      else                       s = s - atan_frac(start + j);
    end
    sc = 1.0;
    for (int b = 0; b < fbits; b++) sc = sc * 2.0;
    return longint'(s * sc);
  endfunction

endpackage

// File: rtl/gaa_delay.sv
module gaa_delay #(
  parameter int WID   = 5,
  parameter int DEPTH = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WID-1:0] d,
  output logic [WID-1:0] q
);

  logic [WID-1:0] sr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= d;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[DEPTH-1];

endmodule

// File: rtl/gaa_stage.sv
module gaa_stage #(
  parameter int ZW    = 28,
  parameter int N     = 5,
  parameter int START = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [ZW-1:0] in_z,
  input  logic [N-1:0]         idx,
  output logic                 out_valid,
  output logic signed [ZW-1:0] out_z
);

  localparam int     TN   = 1 << N;
  localparam longint GMAX = gaa_pkg::group_entry(START, N, TN - 1, ZW - 1);

  logic signed [ZW-1:0] tbl [TN];
  logic signed [ZW-1:0] grp_term;
  logic signed [ZW-1:0] z_next;

  for (genvar e = 0; e < TN; e++) begin : g_tbl
    localparam longint ENT = gaa_pkg::group_entry(START, N, e, ZW - 1);
    assign tbl[e] = ENT[ZW-1:0];
  end

  assign grp_term = tbl[idx];
  assign z_next   = in_z + grp_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_z     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_z <= z_next;
    end
  end

  // one stage never moves the angle by more than its group's full swing
  p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'($signed(out_z - $past(in_z))) <= GMAX &&
                   longint'($signed(out_z - $past(in_z))) >= -GMAX));

endmodule

// File: rtl/gaa_round.sv
module gaa_round #(
  parameter int ZW = 28,
  parameter int W  = 24,
  parameter int G  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [ZW-1:0] in_z,
  output logic                 out_valid,
  output logic [W-1:0]         out_angle
);

  localparam logic signed [ZW-1:0] HALF = ZW'(1) << (G - 1);

  logic signed [ZW-1:0] biased;
  logic [ZW-1:0]        back_scaled;

  assign biased      = in_z + HALF;
  assign back_scaled = {out_angle, {G{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_angle <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_angle <= biased[ZW-1:G];
    end
  end

  // rounding error stays inside (-half, +half] of an output LSB
  p_round_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(back_scaled - $past(in_z)) >  -$signed(HALF) &&
                   $signed(back_scaled - $past(in_z)) <=  $signed(HALF)));

endmodule

// File: rtl/grouped_angle_accum.sv
module grouped_angle_accum #(
  parameter int W       = 24,
  parameter int G       = 4,
  parameter int FIRST_N = 6,
  parameter int REST_N  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir_valid,
  input  logic [W+1:0]   dir_bits,
  output logic           angle_valid,
  output logic [W-1:0]   angle
);

  localparam int NIT = W + 1;
  localparam int ZW  = W + G;
  localparam int NG  = gaa_pkg::group_count(NIT, FIRST_N, REST_N);
  localparam int LAT = NG + 1;
  localparam int CW  = $clog2(LAT + 2);

  localparam logic signed [ZW-1:0] OFS_POS = {2'b01, {(ZW-2){1'b0}}};
  localparam logic signed [ZW-1:0] OFS_NEG = {2'b11, {(ZW-2){1'b0}}};

  logic                 v [NG+1];
  logic signed [ZW-1:0] z [NG+1];

  assign v[0] = dir_valid;
  assign z[0] = dir_bits[0] ? OFS_POS : OFS_NEG;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int ST = gaa_pkg::group_start(k, FIRST_N, REST_N);
    localparam int N  = gaa_pkg::group_size(k, NIT, FIRST_N, REST_N);
    logic [N-1:0] idx_now;
    logic [N-1:0] idx_k;
    assign idx_now = dir_bits[ST+1 +: N];
    if (k == 0) begin : g_direct
      assign idx_k = idx_now;
    end else begin : g_delayed
      gaa_delay #(.WID(N), .DEPTH(k)) u_dly (
        .clk(clk), .rst_n(rst_n), .d(idx_now), .q(idx_k)
      );
    end
    gaa_stage #(.ZW(ZW), .N(N), .START(ST)) u_stg (
      .clk(clk), .rst_n(rst_n),
      .in_valid(v[k]), .in_z(z[k]), .idx(idx_k),
      .out_valid(v[k+1]), .out_z(z[k+1])
    );
  end

  gaa_round #(.ZW(ZW), .W(W), .G(G)) u_rnd (
    .clk(clk), .rst_n(rst_n),
    .in_valid(v[NG]), .in_z(z[NG]),
    .out_valid(angle_valid), .out_angle(angle)
  );

  // vectors in flight, kept only for the checks below
  logic [CW-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CW'(dir_valid) - CW'(angle_valid);
  end

  p_out_has_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    angle_valid |-> inflight != '0);

  p_inflight_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !v[NG] |=> $stable(angle));

endmodule

// File: tb/tb_grouped_angle_accum.sv
module tb_grouped_angle_accum;
  localparam int  W   = 24;
  localparam int  G   = 4;
  localparam int  ZW  = W + G;
  localparam int  DW  = W + 2;
  localparam int  LAT = 6;
  localparam real PI  = 3.14159265358979323846;

  logic          clk = 0, rst_n = 0, dir_valid = 0;
  logic [DW-1:0] dir_bits = '0;
  wire           angle_valid;
  wire  [W-1:0]  angle;

  always #4 clk = ~clk;

  grouped_angle_accum dut (
    .clk(clk), .rst_n(rst_n), .dir_valid(dir_valid), .dir_bits(dir_bits),
    .angle_valid(angle_valid), .angle(angle)
  );

  int checks = 0, errors = 0;
  bit            mv [LAT];
  logic [DW-1:0] mb [LAT];
  logic [W-1:0]  last_angle = '0;
  bit            cur_v = 0;
  logic [DW-1:0] cur_b = '0;
  logic [W-1:0]  res [$];

  function automatic logic [W-1:0] ref_angle(input logic [DW-1:0] b);
    int     sz [5] = '{6, 5, 5, 5, 4};
    int     it = 0;
    longint acc = b[0] ? (64'sd1 <<< (ZW-2)) : -(64'sd1 <<< (ZW-2));
    for (int g = 0; g < 5; g++) begin
      real s = 0.0;
      for (int j = 0; j < sz[g]; j++) begin
        real a = $atan(2.0 ** (-it)) / PI;
        s = b[it+1] ? s + a : s - a;
        it++;
      end
      acc += longint'(s * (2.0 ** (ZW-1)));
    end
    acc = (acc + (64'sd1 <<< (G-1))) >>> G;
    return acc[W-1:0];
  endfunction

  function automatic real err_lsb(input logic [DW-1:0] b, input logic [W-1:0] got);
    real t = b[0] ? 0.5 : -0.5;
    real d;
    for (int i = 0; i <= W; i++) t += (b[i+1] ? 1.0 : -1.0) * $atan(2.0 ** (-i)) / PI;
    d = $itor($signed(got)) / (2.0 ** (W-1)) - t;
    while (d >= 1.0) d -= 2.0;
    while (d < -1.0) d += 2.0;
    if (d < 0.0) d = -d;
    return d * (2.0 ** (W-1));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [DW-1:0] b);
    @(negedge clk);
    for (int i = LAT-1; i > 0; i--) begin mv[i] = mv[i-1]; mb[i] = mb[i-1]; end
    mv[0] = cur_v; mb[0] = cur_b;
    check(angle_valid == mv[LAT-1], "R2 valid timing", angle_valid, mv[LAT-1]);
    if (mv[LAT-1]) begin
      logic [W-1:0] e = ref_angle(mb[LAT-1]);
      check(angle == e, "R3 R5 R6 value", angle, e);
      check(err_lsb(mb[LAT-1], angle) <= 1.0, "R9 accuracy", angle, e);
      last_angle = e;
      res.push_back(angle);
    end else begin
      check(angle == last_angle, "R8 hold", angle, last_angle);
    end
    cur_v = v; cur_b = b; dir_valid = v; dir_bits = b;
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] x;
    for (int i = 0; i < LAT; i++) begin mv[i] = 0; mb[i] = '0; end
    repeat (3) @(negedge clk);
    check(angle_valid == 1'b0, "R1 reset valid", angle_valid, 0);
    check(angle == '0, "R1 reset angle", angle, 0);
    rst_n = 1;
    @(negedge clk);
    check(angle_valid == 1'b0 && angle == '0, "R1 after release", angle, 0);
    // directed: wrap cases and offset pair, back to back
    step(1, {DW{1'b1}});
    step(1, {DW{1'b0}});
    x = DW'({$urandom, $urandom});
    step(1, x | DW'(1));
    step(1, x & ~DW'(1));
    step(1, {(DW/2){2'b10}});
    step(1, {(DW/2){2'b01}});
    for (int i = 0; i < 300; i++) step(1, DW'({$urandom, $urandom}));
    for (int i = 0; i < 300; i++) step(($urandom % 3) == 0, DW'({$urandom, $urandom}));
    for (int i = 0; i < LAT + 3; i++) step(0, '0);
    check(res.size() >= 304, "R2 one output per input", res.size(), 304);
    check(res[0][W-1] == 1'b1, "R7 positive overflow wraps", res[0], 1);
    check(res[1][W-1] == 1'b0, "R7 negative overflow wraps", res[1], 0);
    check(W'(res[2] - res[3]) == W'(1) << (W-1), "R4 offset step",
          W'(res[2] - res[3]), W'(1) << (W-1));
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule